// File: doc/BRIEF.md
# I2C Controller Status, Interrupt and DMA-Request Unit

This block is the flag-and-request part of an I2C master controller. The byte sequencer reports four kinds of bus event as one-cycle pulses: a byte transfer finished, a wait point on the ninth clock, a missing acknowledge from the target, and lost arbitration. The unit latches each pulse in a sticky flag. Beside the flags, the status register mirrors the live bus-busy state and the sampled SCL and SDA levels. Software reads the status and control registers through a plain 8-bit register port. It clears flags by writing zeros to them: a bit written as one keeps its flag, so a read-modify-write clears exactly the bits zeroed in the value read.

A single interrupt line is the OR of every latched flag gated by its enable. The control register holds four event enables and a DMA enable per direction. It also holds the top bits of the SCL low and high period counts, which are handed to the clock generator.

In DMA mode, a transmit request is raised when a byte transfer ends and held until the engine writes the data register. A receive request is raised when a byte has arrived and held until the engine reads the data register. Transmit DMA is normally switched on only after the address byte has gone out. For that reason, turning it on while the end-of-transfer flag is already set also raises a request.

Top module: `i2cs_status_irq`

## Requirements
- R1: After reset every event flag, the whole control register, `irq`, `dma_tx_req` and `dma_rx_req` are zero.
- R2: Status register (address 1) layout: bit7 SCL level, bit6 SDA level, bit5 reads 0, bit4 bus busy, bit3 arbitration lost, bit2 no-acknowledge, bit1 wait, bit0 transfer end. An event pulse sets its flag at the next clock edge, and the flag stays set until it is cleared.
- R3: A write to the status register clears each event flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Writing 0x00 clears all four flags.
- R4: An event pulse in the same cycle as a write that clears its flag wins: the flag is set afterwards.
- R5: Bits 7, 6 and 4 of the status register always show `scl_level`, `sda_level` and `bus_busy`. Writes to status bits 7..4 have no effect.
- R6: `irq` is high exactly when some event flag in status bits 3..0 is set and the control bit at the same position is set.
- R7: Control register (address 2) layout: bit7 low-count top bit, bit6 high-count top bit, bit5 transmit DMA enable, bit4 receive DMA enable, bits3..0 event enables. It reads back as written, and bits 7 and 6 drive `lo_cnt_msb` and `hi_cnt_msb`.
- R8: With transmit DMA enabled, a transfer-end pulse raises `dma_tx_req`. Turning transmit DMA on while the transfer-end flag is set also raises it, one cycle after the enabling write. The request stays high until a write to the data register (address 0).
- R9: With receive DMA enabled, a `rx_byte_ready` pulse raises `dma_rx_req`. It stays high until a read of the data register (address 0); data-register writes do not drop it.
- R10: With the matching DMA enable clear, transfer-end and `rx_byte_ready` pulses raise no DMA request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 reads zero |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to retire receive requests) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| evt_dte | input | 1 | Byte transfer finished pulse |
| evt_wait | input | 1 | Ninth-clock wait pulse |
| evt_nack | input | 1 | No acknowledge pulse |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| rx_byte_ready | input | 1 | Received byte available pulse |
| bus_busy | input | 1 | Bus busy level |
| scl_level | input | 1 | Sampled SCL |
| sda_level | input | 1 | Sampled SDA |
| irq | output | 1 | Interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| lo_cnt_msb | output | 1 | Bit 8 of the SCL low count |
| hi_cnt_msb | output | 1 | Bit 8 of the SCL high count |

## Verification
The flags are driven one event at a time and then all together. Masked read-modify-write patterns such as 0xFB and 0xFD show that a write clears only the zeroed bits and does not reset the whole register. Writing a pulse and a clearing write in the same cycle separates set-priority from clear-priority. Interrupt tests pair set flags with mismatched and matched enables, which catches a wrong bit lane or an unmasked OR. DMA tests cover the transfer-end pulse after enabling, late enabling over a flag that is already set, retirement by the correct and the wrong data access, and pulses with DMA disabled.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int NUM_EVT = 4;
  localparam int REG_W   = 8;

  // flag lanes, equal to their status bit positions
  localparam int F_DTE  = 0;
  localparam int F_WAIT = 1;
  localparam int F_NACK = 2;
  localparam int F_ARB  = 3;

  // control register fields
  localparam int C_RXDMA = 4;
  localparam int C_TXDMA = 5;
  localparam int C_HIMSB = 6;
  localparam int C_LOMSB = 7;

  typedef enum logic [1:0] {
    ADR_DATA  = 2'd0,
    ADR_STAT  = 2'd1,
    ADR_CTRL  = 2'd2,
    ADR_SPARE = 2'd3
  } reg_addr_e;

  // next flag value: a write clears bits written as 0; events win
  function automatic logic [NUM_EVT-1:0] flag_next(
    input logic [NUM_EVT-1:0] cur,
    input logic               clr_we,
    input logic [NUM_EVT-1:0] keep_mask,
    input logic [NUM_EVT-1:0] evt
  );
    logic [NUM_EVT-1:0] kept;
    kept = clr_we ? (cur & keep_mask) : cur;
    return kept | evt;
  endfunction

  function automatic logic irq_any(
    input logic [NUM_EVT-1:0] flags,
    input logic [NUM_EVT-1:0] en
  );
    return |(flags & en);
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
    input logic scl, input logic sda, input logic busy,
    input logic [NUM_EVT-1:0] flags
  );
    return {scl, sda, 1'b0, busy, flags};
  endfunction

endpackage

// File: rtl/i2cs_flag_bank.sv
module i2cs_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] keep_mask,
  output logic [N-1:0] flags
);
  import i2cs_pkg::*;

  logic [N-1:0] nxt;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      logic nb;
      assign nb = (clr_we ? (flags[i] & keep_mask[i]) : flags[i]) | evt[i];
      assign nxt[i] = nb;
      always_ff @(posedge clk) begin
        if (!rst_n) flags[i] <= 1'b0;
        else        flags[i] <= nxt[i];
      end
    end
  endgenerate

endmodule

// File: rtl/i2cs_ctrl_reg.sv
module i2cs_ctrl_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl
);
  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl <= '0;
    else if (we) ctrl <= wdata;
  end
endmodule

// File: rtl/i2cs_dma_req.sv
module i2cs_dma_req #(
  parameter int NDIR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIR-1:0] arm,
  input  logic [NDIR-1:0] retire,
  output logic [NDIR-1:0] req
);
  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      always_ff @(posedge clk) begin
        if (!rst_n)         req[d] <= 1'b0;
        else if (arm[d])    req[d] <= 1'b1;
        else if (retire[d]) req[d] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/i2cs_status_irq.sv
module i2cs_status_irq
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              evt_dte,
  input  logic              evt_wait,
  input  logic              evt_nack,
  input  logic              evt_arb_lost,
  input  logic              rx_byte_ready,
  input  logic              bus_busy,
  input  logic              scl_level,
  input  logic              sda_level,
  output logic              irq,
  output logic              dma_tx_req,
  output logic              dma_rx_req,
  output logic              lo_cnt_msb,
  output logic              hi_cnt_msb
);

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;

  // named internal events
  logic               stat_we, ctrl_we, data_we, data_re;
  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] flag_q;
  logic [REG_W-1:0]   ctrl_q;
  logic               tx_en, rx_en, tx_en_d;
  logic               tx_late_arm;
  logic [1:0]         dma_arm, dma_retire, dma_req;

  assign stat_we = reg_wr && (reg_addr == ADDR_W'(ADR_STAT));
  assign ctrl_we = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));
  assign data_we = reg_wr && (reg_addr == ADDR_W'(ADR_DATA));
  assign data_re = reg_rd && (reg_addr == ADDR_W'(ADR_DATA));

  always_comb begin
    evt_vec         = '0;
    evt_vec[F_DTE]  = evt_dte;
    evt_vec[F_WAIT] = evt_wait;
    evt_vec[F_NACK] = evt_nack;
    evt_vec[F_ARB]  = evt_arb_lost;
  end

  i2cs_flag_bank #(.N(NUM_EVT)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt_vec),
    .clr_we    (stat_we),
    .keep_mask (reg_wdata[NUM_EVT-1:0]),
    .flags     (flag_q)
  );

  i2cs_ctrl_reg #(.W(REG_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .wdata (reg_wdata),
    .ctrl  (ctrl_q)
  );

  assign tx_en      = ctrl_q[C_TXDMA];
  assign rx_en      = ctrl_q[C_RXDMA];
  assign lo_cnt_msb = ctrl_q[C_LOMSB];
  assign hi_cnt_msb = ctrl_q[C_HIMSB];

  always_ff @(posedge clk) begin
    if (!rst_n) tx_en_d <= 1'b0;
    else        tx_en_d <= tx_en;
  end

  // enabling transmit DMA over an already finished byte
  assign tx_late_arm = tx_en && !tx_en_d && flag_q[F_DTE];

  assign dma_arm[DIR_TX]    = (tx_en && evt_dte) || tx_late_arm;
  assign dma_arm[DIR_RX]    = rx_en && rx_byte_ready;
  assign dma_retire[DIR_TX] = data_we;
  assign dma_retire[DIR_RX] = data_re;

  i2cs_dma_req #(.NDIR(2)) u_dma (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (dma_arm),
    .retire (dma_retire),
    .req    (dma_req)
  );

  assign dma_tx_req = dma_req[DIR_TX];
  assign dma_rx_req = dma_req[DIR_RX];

  assign irq = irq_any(flag_q, ctrl_q[NUM_EVT-1:0]);

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(ADR_STAT): reg_rdata = pack_status(scl_level, sda_level, bus_busy, flag_q);
      ADDR_W'(ADR_CTRL): reg_rdata = ctrl_q;
      default:           reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/i2cs_status_irq_chk.sv
module i2cs_status_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_we,
  input logic       ctrl_we,
  input logic       data_we,
  input logic       data_re,
  input logic [7:0] reg_wdata,
  input logic [3:0] evt_vec,
  input logic [3:0] flag_q,
  input logic [7:0] ctrl_q,
  input logic       rx_byte_ready,
  input logic       evt_dte,
  input logic       irq,
  input logic       dma_tx_req,
  input logic       dma_rx_req,
  input logic       lo_cnt_msb,
  input logic       hi_cnt_msb
);

  // R2: an event pulse leaves its flag set
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != 4'd0) |=> ((flag_q & $past(evt_vec)) == $past(evt_vec)));

  // R3: without events, a status write keeps only bits written as 1
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && evt_vec == 4'd0) |=> (flag_q == ($past(flag_q) & $past(reg_wdata[3:0]))));

  // R2: flags do not change without event or write
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_we && evt_vec == 4'd0) |=> $stable(flag_q));

  // R6: interrupt tracks enabled flags
  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((flag_q & ctrl_q[3:0]) != 4'd0));

  // R7: count top bits follow control writes
  p_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (lo_cnt_msb == $past(reg_wdata[7]) && hi_cnt_msb == $past(reg_wdata[6])));

  // R8: a pending transmit request holds until a data write
  p_txhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_tx_req && !data_we) |=> dma_tx_req);

  // R9: a received byte with receive DMA on raises the request
  p_rxset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_ready && ctrl_q[4]) |=> dma_rx_req);

  // R10: requests only rise with their enable on
  p_txgate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_tx_req) |-> $past(ctrl_q[5]));
  p_rxgate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_rx_req) |-> $past(ctrl_q[4]));

endmodule

bind i2cs_status_irq i2cs_status_irq_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stat_we       (stat_we),
  .ctrl_we       (ctrl_we),
  .data_we       (data_we),
  .data_re       (data_re),
  .reg_wdata     (reg_wdata),
  .evt_vec       (evt_vec),
  .flag_q        (flag_q),
  .ctrl_q        (ctrl_q),
  .rx_byte_ready (rx_byte_ready),
  .evt_dte       (evt_dte),
  .irq           (irq),
  .dma_tx_req    (dma_tx_req),
  .dma_rx_req    (dma_rx_req),
  .lo_cnt_msb    (lo_cnt_msb),
  .hi_cnt_msb    (hi_cnt_msb)
);

// File: tb/test_i2cs_status_irq.sv
module test_i2cs_status_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       evt_dte = 0, evt_wait = 0, evt_nack = 0, evt_arb_lost = 0;
  logic       rx_byte_ready = 0;
  logic       bus_busy = 0, scl_level = 1, sda_level = 1;
  logic       irq, dma_tx_req, dma_rx_req, lo_cnt_msb, hi_cnt_msb;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  i2cs_status_irq i_i2cs_status_irq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_dte(evt_dte), .evt_wait(evt_wait),
    .evt_nack(evt_nack), .evt_arb_lost(evt_arb_lost), .rx_byte_ready(rx_byte_ready),
    .bus_busy(bus_busy), .scl_level(scl_level), .sda_level(sda_level), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .lo_cnt_msb(lo_cnt_msb),
    .hi_cnt_msb(hi_cnt_msb)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic data_read();
    @(negedge clk);
    reg_addr = 2'd0; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // pulse: bit0 dte, bit1 wait, bit2 nack, bit3 arb, bit4 rx ready
  task automatic pulse(input logic [4:0] e);
    @(negedge clk);
    {rx_byte_ready, evt_arb_lost, evt_nack, evt_wait, evt_dte} = e;
    @(negedge clk);
    {rx_byte_ready, evt_arb_lost, evt_nack, evt_wait, evt_dte} = 5'd0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd1, v); check("R1 status after reset", v, 8'hC0);
    rd(2'd2, v); check("R1 control after reset", v, 8'h00);
    check("R1 outputs after reset", {4'd0, irq, dma_tx_req, dma_rx_req, lo_cnt_msb}, 8'h00);
  endtask

  task automatic t_events();
    logic [7:0] v;
    pulse(5'b00010); rd(2'd1, v); check("R2 wait flag", v, 8'hC2);
    idle(3);         rd(2'd1, v); check("R2 flag sticky", v, 8'hC2);
    pulse(5'b01101); rd(2'd1, v); check("R2 all flags", v, 8'hCF);
    check("R6 no enables no irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(2'd1, 8'hFB); rd(2'd1, v); check("R3 clear nack only", v, 8'hCB);
    wr(2'd1, 8'hF6); rd(2'd1, v); check("R3 clear arb and dte", v, 8'hC2);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R3 clear all", v, 8'hC0);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    bus_busy = 1; scl_level = 0; sda_level = 1;
    rd(2'd1, v); check("R5 mirrors", v, 8'h50);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R5 write 0 ignored", v, 8'h50);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R5 write 1 ignored", v, 8'h50);
    bus_busy = 0; scl_level = 1; sda_level = 0;
    rd(2'd1, v); check("R5 mirrors follow", v, 8'h80);
    sda_level = 1;
  endtask

  task automatic t_irq();
    wr(2'd2, 8'h02);
    pulse(5'b00001); check("R6 masked dte", {7'd0, irq}, 8'h00);
    pulse(5'b00010); check("R6 enabled wait", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'hFD); check("R6 wait cleared", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h01); check("R6 dte enabled", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h00); check("R6 dte cleared", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h08); pulse(5'b01000); check("R6 arb lane", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(2'd2, 8'hC0); rd(2'd2, v); check("R7 readback", v, 8'hC0);
    check("R7 msbs both", {6'd0, lo_cnt_msb, hi_cnt_msb}, 8'h03);
    wr(2'd2, 8'h80); check("R7 low msb", {6'd0, lo_cnt_msb, hi_cnt_msb}, 8'h02);
    wr(2'd2, 8'h5A); rd(2'd2, v); check("R7 readback mixed", v, 8'h5A);
    check("R7 high msb", {6'd0, lo_cnt_msb, hi_cnt_msb}, 8'h01);
    rd(2'd3, v); check("R7 spare reads zero", v, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    pulse(5'b00110);
    @(negedge clk);
    reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1; evt_dte = 1'b1; evt_wait = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_dte = 1'b0; evt_wait = 1'b0;
    rd(2'd1, v); check("R4 event beats clear", v, 8'hC3);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_tx_dma();
    pulse(5'b00001); idle(1);
    check("R10 no tx req when disabled", {7'd0, dma_tx_req}, 8'h00);
    wr(2'd2, 8'h20); check("R8 late arm not yet", {7'd0, dma_tx_req}, 8'h00);
    idle(1); check("R8 late arm raises", {7'd0, dma_tx_req}, 8'h01);
    idle(3); check("R8 request held", {7'd0, dma_tx_req}, 8'h01);
    data_read(); check("R8 read does not retire tx", {7'd0, dma_tx_req}, 8'h01);
    wr(2'd0, 8'hA5); check("R8 data write retires", {7'd0, dma_tx_req}, 8'h00);
    pulse(5'b00001); check("R8 dte pulse raises", {7'd0, dma_tx_req}, 8'h01);
    wr(2'd0, 8'h3C); check("R8 retired again", {7'd0, dma_tx_req}, 8'h00);
    wr(2'd2, 8'h00); wr(2'd1, 8'h00);
  endtask

  task automatic t_rx_dma();
    pulse(5'b10000); check("R10 no rx req when disabled", {7'd0, dma_rx_req}, 8'h00);
    wr(2'd2, 8'h10); idle(1);
    check("R9 enable alone no req", {7'd0, dma_rx_req}, 8'h00);
    pulse(5'b10000); check("R9 rx ready raises", {7'd0, dma_rx_req}, 8'h01);
    wr(2'd0, 8'h11); check("R9 write does not retire", {7'd0, dma_rx_req}, 8'h01);
    data_read(); check("R9 data read retires", {7'd0, dma_rx_req}, 8'h00);
    check("R10 rx path left tx alone", {7'd0, dma_tx_req}, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_events();
    t_clear();
    t_readonly();
    t_irq();
    t_ctrl();
    t_same_cycle();
    t_tx_dma();
    t_rx_dma();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule